// File: doc/BRIEF.md
# Serial Character Framer with Line Break

This block does the serial framing for one asynchronous serial port. A 16-bit divisor sets a baud tick, and sixteen ticks make one bit period. On the transmit side it accepts one parallel character through a valid/ready port. It then sends a start bit, the data bits least significant first, an optional parity bit and the selected stop time, and returns the line to its high idle level. A separate control can hold the transmit line low to send a break.

On the receive side the incoming line is first synchronised. The receiver finds a start bit on a tick and confirms it half a bit later. Each following bit is sampled in the middle of its period. Each character is delivered with parity-error, framing-error and break flags. A break is a line held low for a whole character time including stop time. It is delivered as a zero character with the break flag set. After any character whose stop bit was low, the receiver waits for the line to go high before it looks for the next start bit.

The configuration inputs are expected to stay steady while a character is in flight.

Top module: `serial_char_framer`

## Requirements
- R1: With divisor N ≥ 1 the block makes one baud tick every N clock cycles, and every bit period is 16 ticks. With divisor 0 no tick occurs: a character that has been accepted stays frozen, tx_ready stays low and txd holds its level.
- R2: txd is high while idle. A frame is a low start bit, then cfg_len+5 data bits least significant first (cfg_len 0..3 gives 5..8 bits), then parity if enabled, then stop time at high level.
- R3: cfg_par selects parity: 2'b01 even, 2'b10 odd, 2'b00 and 2'b11 none. With even parity the data bits plus the parity bit hold an even number of ones; with odd parity they hold an odd number.
- R4: cfg_stop selects the stop time: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks (1.5 bits), 2'b10 and 2'b11 give 32 ticks. tx_ready returns high at the end of the stop time.
- R5: A character is accepted in a cycle where tx_valid and tx_ready are both high. tx_ready is low from the next cycle until the frame ends.
- R6: While cfg_break is high, txd is low, whether the transmitter is idle or busy.
- R7: The receiver detects a start on a tick where the synchronised line is low. It samples the start bit 8 ticks later and each later bit 16 ticks after the one before. rx_data holds the data right-justified, with the unused upper bits zero.
- R8: A start bit that is high at its mid-bit sample is discarded, and no character is delivered.
- R9: rx_perr is set with a character whose parity bit does not match the selected parity. It is zero when parity is off.
- R10: rx_ferr is set when the first stop bit samples low. After such a character the receiver does not look for a new start until the line has been high.
- R11: If the start bit, all data bits, the parity bit and the line through the end of the stop time are all low, the character is delivered as a break: rx_data 0, rx_brk 1, rx_ferr 1, rx_perr 0. The receiver then waits for the line to go high.
- R12: rx_valid stays high until a cycle with rx_ready high. A new character that arrives before that replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_divisor | input | DIV_W | Clock cycles per baud tick; 0 stops the tick |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity select (01 even, 10 odd, else none) |
| cfg_stop | input | 2 | Stop time select (00 one, 01 one and a half, else two bits) |
| cfg_break | input | 1 | Force the transmit line low |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 8 | Transmit character |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received character held |
| rx_data | output | 8 | Received character, right-justified |
| rx_perr | output | 1 | Parity error for the held character |
| rx_ferr | output | 1 | Framing error for the held character |
| rx_brk | output | 1 | Held character is a line break |
| rx_ready | input | 1 | Consumer takes the held character |

## Verification
The bench keeps the default divisor width and drives the divisor at run time. A divisor of 1 puts every bit edge on an exact cycle, so the bench sweeps all 36 combinations of length, parity and stop time in both directions. A divisor of 3 moves tick phase against the start of a frame, so the bench checks the frame length as a cycle window and the mid-bit sampling with jitter. Separate cases cover a divisor of 0, a forced break, a false start, a bad stop bit, breaks with and without extra stop time, and overwriting a held character.

// File: rtl/serial_char_framer.sv
module serial_char_framer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic             cfg_break,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_brk,
  input  logic             rx_ready
);
  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOPX, S_WAIT} st_t;

  logic [DIV_W-1:0] bcnt;
  logic             tick;
  assign tick = (cfg_divisor != '0) && (bcnt >= cfg_divisor - DIV_ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             bcnt <= '0;
    else if (tick || cfg_divisor == '0)     bcnt <= '0;
    else                                    bcnt <= bcnt + DIV_ONE;

  logic [3:0] last_idx;
  logic [5:0] stop_ticks;
  logic [7:0] mask;
  logic       par_en, par_odd;
  assign last_idx   = 4'd4 + {2'b00, cfg_len};
  assign stop_ticks = (cfg_stop == 2'b00) ? 6'd16 : (cfg_stop == 2'b01) ? 6'd24 : 6'd32;
  assign mask       = ~(8'hE0 << cfg_len);
  assign par_en     = (cfg_par == 2'b01) || (cfg_par == 2'b10);
  assign par_odd    = (cfg_par == 2'b10);

  st_t        tx_st;
  logic [5:0] tx_cnt;
  logic [2:0] tx_idx;
  logic [7:0] tx_sh;
  logic       tx_pbit;
  logic [5:0] tx_last;
  assign tx_last = (tx_st == S_STOP) ? stop_ticks - 6'd1 : 6'd15;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st <= S_IDLE; tx_cnt <= '0; tx_idx <= '0; tx_sh <= '0; tx_pbit <= 1'b0;
    end else if (tx_st == S_IDLE) begin
      if (tx_valid) begin
        tx_sh   <= tx_data & mask;
        tx_pbit <= (^(tx_data & mask)) ^ par_odd;
        tx_cnt  <= '0;
        tx_idx  <= '0;
        tx_st   <= S_START;
      end
    end else if (tick) begin
      if (tx_cnt == tx_last) begin
        tx_cnt <= '0;
        case (tx_st)
          S_START: tx_st <= S_DATA;
          S_DATA: begin
            tx_sh  <= tx_sh >> 1;
            tx_idx <= tx_idx + 3'd1;
            if ({1'b0, tx_idx} == last_idx) tx_st <= par_en ? S_PAR : S_STOP;
          end
          S_PAR:   tx_st <= S_STOP;
          default: tx_st <= S_IDLE;
        endcase
      end else begin
        tx_cnt <= tx_cnt + 6'd1;
      end
    end
  end

  assign tx_ready = (tx_st == S_IDLE);
  assign txd = cfg_break ? 1'b0 :
               (tx_st == S_START) ? 1'b0 :
               (tx_st == S_DATA)  ? tx_sh[0] :
               (tx_st == S_PAR)   ? tx_pbit : 1'b1;

  logic       rx_m, rx_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rx_m <= 1'b1; rx_s <= 1'b1; end
    else        begin rx_m <= rxd;  rx_s <= rx_m; end

  st_t        rx_st;
  logic [5:0] rx_cnt;
  logic [2:0] rx_idx;
  logic [7:0] rx_sh;
  logic       rx_pacc, rx_zero, rx_pe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= S_IDLE; rx_cnt <= '0; rx_idx <= '0; rx_sh <= '0;
      rx_pacc <= 1'b0; rx_zero <= 1'b0; rx_pe <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_brk <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (rx_st)
        S_IDLE:
          if (tick && !rx_s) begin rx_st <= S_START; rx_cnt <= '0; end
        S_START:
          if (tick) begin
            if (rx_cnt == 6'd7) begin
              rx_cnt <= '0;
              if (rx_s) rx_st <= S_IDLE;
              else begin
                rx_st <= S_DATA; rx_idx <= '0; rx_sh <= '0;
                rx_pacc <= 1'b0; rx_zero <= 1'b1; rx_pe <= 1'b0;
              end
            end else rx_cnt <= rx_cnt + 6'd1;
          end
        S_DATA:
          if (tick) begin
            if (rx_cnt == 6'd15) begin
              rx_cnt <= '0;
              rx_sh[rx_idx] <= rx_s;
              rx_pacc <= rx_pacc ^ rx_s;
              rx_zero <= rx_zero & ~rx_s;
              rx_idx  <= rx_idx + 3'd1;
              if ({1'b0, rx_idx} == last_idx) rx_st <= par_en ? S_PAR : S_STOP;
            end else rx_cnt <= rx_cnt + 6'd1;
          end
        S_PAR:
          if (tick) begin
            if (rx_cnt == 6'd15) begin
              rx_cnt  <= '0;
              rx_pe   <= rx_pacc ^ rx_s ^ par_odd;
              rx_zero <= rx_zero & ~rx_s;
              rx_st   <= S_STOP;
            end else rx_cnt <= rx_cnt + 6'd1;
          end
        S_STOP:
          if (tick) begin
            if (rx_cnt == 6'd15) begin
              rx_cnt <= '0;
              if (rx_s) begin
                rx_valid <= 1'b1; rx_data <= rx_sh; rx_perr <= rx_pe;
                rx_ferr <= 1'b0; rx_brk <= 1'b0; rx_st <= S_IDLE;
              end else if (rx_zero && stop_ticks == 6'd16) begin
                rx_valid <= 1'b1; rx_data <= '0; rx_perr <= 1'b0;
                rx_ferr <= 1'b1; rx_brk <= 1'b1; rx_st <= S_WAIT;
              end else if (rx_zero) begin
                rx_st <= S_STOPX;
              end else begin
                rx_valid <= 1'b1; rx_data <= rx_sh; rx_perr <= rx_pe;
                rx_ferr <= 1'b1; rx_brk <= 1'b0; rx_st <= S_WAIT;
              end
            end else rx_cnt <= rx_cnt + 6'd1;
          end
        S_STOPX:
          if (tick) begin
            if (rx_cnt == stop_ticks - 6'd17) begin
              rx_cnt   <= '0;
              rx_valid <= 1'b1;
              rx_data  <= '0;
              rx_ferr  <= 1'b1;
              if (!rx_s) begin
                rx_perr <= 1'b0; rx_brk <= 1'b1; rx_st <= S_WAIT;
              end else begin
                rx_perr <= rx_pe; rx_brk <= 1'b0; rx_st <= S_IDLE;
              end
            end else rx_cnt <= rx_cnt + 6'd1;
          end
        default:
          if (rx_s) rx_st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_char_framer_chk.sv
module serial_char_framer_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_divisor,
  input logic [1:0]       cfg_len,
  input logic             cfg_break,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             txd,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             rx_perr,
  input logic             rx_ferr,
  input logic             rx_brk,
  input logic             rx_ready
);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !cfg_break) |-> txd);

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r1_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_divisor == '0 && !tx_ready) |=>
      (!tx_ready && (txd == $past(txd) || cfg_break != $past(cfg_break))));

  a_r12_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  a_r11_break_char: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_data == 8'd0 && rx_ferr && !rx_perr));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (((rx_data >> 5) >> cfg_len) == 8'd0));
endmodule

bind serial_char_framer serial_char_framer_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/serial_char_framer_test.sv
module serial_char_framer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] cfg_divisor = 16'd1;
  logic [1:0]  cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic        cfg_break = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'd0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic        rx_valid, rx_perr, rx_ferr, rx_brk;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;

  serial_char_framer uut (.*);

  int checks = 0, fails = 0;
  int D = 1;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int nb();      return 5 + int'(cfg_len); endfunction
  function automatic int pe();      return (cfg_par == 2'd1 || cfg_par == 2'd2) ? 1 : 0; endfunction
  function automatic int stt();     return (cfg_stop == 2'd0) ? 16 : (cfg_stop == 2'd1) ? 24 : 32; endfunction
  function automatic logic [7:0] mk(); return 8'((1 << nb()) - 1); endfunction
  function automatic logic pb(logic [7:0] d); return (^(d & mk())) ^ (cfg_par == 2'd2); endfunction

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic tx_frame(logic [7:0] d);
    int c, T, lo, hi;
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
    cyc(8*D); c = 8*D;
    chk("R2 start bit low", int'(txd), 0);
    for (int j = 0; j < nb(); j++) begin
      cyc(16*D); c += 16*D;
      chk($sformatf("R2 data bit %0d len %0d", j, nb()), int'(txd), int'(d[j]));
    end
    if (pe() == 1) begin
      cyc(16*D); c += 16*D;
      chk($sformatf("R3 parity bit par %0d", cfg_par), int'(txd), int'(pb(d)));
    end
    cyc(16*D); c += 16*D;
    chk("R4 stop bit high", int'(txd), 1);
    while (!tx_ready && c < 2000*D) begin @(negedge clk); c++; end
    T  = 16*(1 + nb() + pe()) + stt();
    lo = (T-1)*D + 1; hi = T*D;
    if (c < lo || c > hi) chk($sformatf("R4 R1 frame length stop %0d", cfg_stop), c, hi);
    else chk("R4 R1 frame length", c, c);
  endtask

  task automatic drive_bits(logic [7:0] d, logic flip_par);
    rxd = 1'b0; cyc(16*D);
    for (int j = 0; j < nb(); j++) begin rxd = d[j]; cyc(16*D); end
    if (pe() == 1) begin rxd = pb(d) ^ flip_par; cyc(16*D); end
  endtask

  task automatic ack();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
    chk("R12 rx_valid cleared by rx_ready", int'(rx_valid), 0);
  endtask

  task automatic rx_frame(logic [7:0] d, logic flip_par);
    drive_bits(d, flip_par);
    rxd = 1'b1; cyc(stt()*D + 16*D);
    chk("R7 rx_valid", int'(rx_valid), 1);
    chk($sformatf("R7 rx_data len %0d", nb()), int'(rx_data), int'(d & mk()));
    chk($sformatf("R9 rx_perr par %0d", cfg_par), int'(rx_perr), int'(flip_par && pe() == 1));
    chk("R10 rx_ferr clear", int'(rx_ferr), 0);
    chk("R11 rx_brk clear", int'(rx_brk), 0);
    ack();
  endtask

  task automatic setcfg(int l, int p, int s);
    @(negedge clk);
    cfg_len = 2'(l); cfg_par = 2'(p); cfg_stop = 2'(s);
  endtask

  task automatic break_case(int l, int p, int s);
    int lowlen;
    setcfg(l, p, s);
    lowlen = (16*(1 + nb() + pe()) + stt() + 16) * D;
    rxd = 1'b0; cyc(lowlen);
    chk("R11 break rx_valid", int'(rx_valid), 1);
    chk("R11 break rx_brk", int'(rx_brk), 1);
    chk("R11 break rx_data zero", int'(rx_data), 0);
    chk("R11 break rx_ferr", int'(rx_ferr), 1);
    chk("R11 break rx_perr", int'(rx_perr), 0);
    ack();
    cyc(64*D);
    chk("R11 no start while line stays low", int'(rx_valid), 0);
    rxd = 1'b1; cyc(32*D);
    rx_frame(8'h6A, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(4); rst_n = 1'b1; cyc(2);
    chk("R5 reset tx_ready", int'(tx_ready), 1);
    chk("R2 reset txd idle high", int'(txd), 1);
    chk("R12 reset rx_valid", int'(rx_valid), 0);

    cfg_break = 1'b1; cyc(2);
    chk("R6 forced break at idle", int'(txd), 0);
    cfg_break = 1'b0; cyc(2);
    chk("R6 break released", int'(txd), 1);

    D = 1; cfg_divisor = 16'd1;
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 3; s++) begin
          setcfg(l, p, s);
          tx_frame(8'hB6); tx_frame(8'h4D);
          rx_frame(8'hB6, 1'b0); rx_frame(8'h4D, 1'b0);
          if (p != 0) rx_frame(8'h93, 1'b1);
        end

    setcfg(3, 3, 3);
    tx_frame(8'hC3); rx_frame(8'hC3, 1'b1);

    D = 3; cfg_divisor = 16'd3;
    for (int k = 0; k < 6; k++) begin
      setcfg(k % 4, k % 3, (k + 1) % 3);
      tx_frame(8'h5A); tx_frame(8'hE1);
      rx_frame(8'h5A, 1'b0); rx_frame(8'hE1, 1'b1);
    end

    setcfg(3, 1, 0);
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA7;
    @(negedge clk); tx_valid = 1'b0;
    cfg_break = 1'b1; cyc(16*D);
    chk("R6 forced break while busy", int'(txd), 0);
    cfg_break = 1'b0;
    while (!tx_ready) @(negedge clk);

    @(negedge clk); cfg_divisor = 16'd0;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hFF;
    @(negedge clk); tx_valid = 1'b0;
    cyc(300);
    chk("R1 divisor zero holds start bit", int'(txd), 0);
    chk("R1 divisor zero keeps busy", int'(tx_ready), 0);
    cfg_divisor = 16'd1; D = 1;
    cyc(16*12 + 40);
    chk("R1 frame completes once tick returns", int'(tx_ready), 1);

    D = 2; cfg_divisor = 16'd2;
    setcfg(3, 0, 0);
    rxd = 1'b0; cyc(6*D); rxd = 1'b1; cyc(40*D);
    chk("R8 false start delivers nothing", int'(rx_valid), 0);
    rx_frame(8'h81, 1'b0);

    drive_bits(8'h55, 1'b0);
    rxd = 1'b0; cyc(16*D);
    chk("R10 ferr rx_valid", int'(rx_valid), 1);
    chk("R10 ferr flag", int'(rx_ferr), 1);
    chk("R10 ferr data kept", int'(rx_data), 8'h55);
    chk("R10 ferr not break", int'(rx_brk), 0);
    ack();
    cyc(64*D);
    chk("R10 waits for line high", int'(rx_valid), 0);
    rxd = 1'b1; cyc(32*D);
    rx_frame(8'h3E, 1'b0);

    break_case(3, 2, 1);
    break_case(0, 0, 0);
    break_case(2, 1, 2);

    setcfg(3, 0, 0);
    drive_bits(8'h12, 1'b0); rxd = 1'b1; cyc(32*D);
    cyc(40*D);
    chk("R12 first held", int'(rx_valid), 1);
    chk("R12 first data", int'(rx_data), 8'h12);
    drive_bits(8'hC4, 1'b0); rxd = 1'b1; cyc(32*D);
    chk("R12 still valid", int'(rx_valid), 1);
    chk("R12 overwritten by newer", int'(rx_data), 8'hC4);
    ack();

    finish_run();
  end
endmodule